// File: doc/BRIEF.md
# Ineffectual Instruction Removal Detector

This block observes the retirement stream of the trailing, full-length copy of a program that runs as a pair of redundant processes. It learns which dynamic instructions are repeatedly without observable effect, so that the leading copy can skip them. Three conditions count as ineffectual. The first is a store that writes the value already held at its location. The second is a store whose location is written again before any load reads it. The third is a conditional branch whose prediction was correct. Every instruction that retires still runs in the trailing copy. Only the leading copy drops flagged instructions.

A direct-mapped confidence table, indexed by the low PC bits, holds a PC tag and a saturating counter for each entry. An ineffectual event raises the counter by one. An effectual event clears it. A second small direct-mapped table, indexed by the low address bits, remembers the most recent store that changed memory and has not yet been read. This lets a later overwrite credit that earlier store. The fetch stage of the leading copy presents a PC on a lookup port. The block answers combinationally with a skip flag. A flush input erases all learned confidence when misspeculation recovery happens.

Top module: `skip_trainer`

## Requirements
- R1: After reset, lk_skip is 0 for every lookup PC.
- R2: A retired branch (rt_kind 2'b11) adds one to its PC's counter when rt_mispred is 0 and clears that counter to 0 when rt_mispred is 1.
- R3: A retired store (rt_kind 2'b01) with rt_wdata equal to rt_olddata adds one to its own PC's counter.
- R4: A retired store with rt_wdata different from rt_olddata does not change its own counter. It becomes the pending write for its address. A later store to the same address, with no load to that address in between, adds one to the pending writer's counter.
- R5: A retired load (rt_kind 2'b10) to an address with a pending write clears the pending writer's counter to 0 and removes the pending record. A later store to that address then credits no one.
- R6: lk_skip is 1 only when the entry selected by lk_pc holds lk_pc's tag and its counter equals the maximum value (7 for a 3-bit counter). The counter saturates at that maximum.
- R7: An increment aimed at an entry that holds a different tag replaces the entry with the new tag and a count of 1. A clear aimed at a different tag has no effect.
- R8: When a store's own increment and the credit to a pending writer select the same confidence entry in one cycle, only the store's own event is applied. Two events for the same PC add one, not two.
- R9: flush clears every counter and every pending write record in one cycle. A retirement presented in the same cycle is ignored.
- R10: Nothing changes when rt_valid is 0 or rt_kind is 2'b00 (any other instruction).
- R11: A pending write record is replaced without credit when a changing store to a different address maps to the same pending-write slot. A later store to the first address then credits no one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all confidence and pending writes |
| rt_valid | input | 1 | A retirement is presented this cycle |
| rt_kind | input | 2 | 00 other, 01 store, 10 load, 11 branch |
| rt_pc | input | PC_W | PC of the retiring instruction |
| rt_addr | input | ADDR_W | Memory word address of a load or store |
| rt_wdata | input | DATA_W | Value written by a store |
| rt_olddata | input | DATA_W | Value held at the store address before the write |
| rt_mispred | input | 1 | Branch was mispredicted |
| lk_pc | input | PC_W | Fetch PC of the leading program |
| lk_skip | output | 1 | Instruction at lk_pc may be skipped |

## Verification
A wrong counter or tag shows at lk_skip only once the affected entry reaches or leaves the maximum. An off-by-one in training therefore appears one retirement early or late. A missed clear appears as a skip flag that stays high after a mispredict, a load or a flush. Directed sequences drive an entry to exactly one below the threshold and then one step further. Each of these faults becomes visible on the first lookup after the deciding retirement. A shadow model in the bench checks the lookup on every cycle of a random phase.

// File: rtl/skip_trainer.sv
module skip_trainer #(
  parameter int PC_W       = 16,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int CONF_IDX_W = 4,
  parameter int WT_IDX_W   = 3,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rt_valid,
  input  logic [1:0]        rt_kind,
  input  logic [PC_W-1:0]   rt_pc,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [DATA_W-1:0] rt_wdata,
  input  logic [DATA_W-1:0] rt_olddata,
  input  logic              rt_mispred,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_skip
);
  localparam int CE    = 1 << CONF_IDX_W;
  localparam int WE    = 1 << WT_IDX_W;
  localparam int TAG_W = PC_W - CONF_IDX_W;
  localparam int AT_W  = ADDR_W - WT_IDX_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [1:0] K_STORE = 2'b01, K_LOAD = 2'b10, K_BRANCH = 2'b11;

  logic [TAG_W-1:0] tag_q [CE];
  logic [CNT_W-1:0] cnt_q [CE];
  logic             wv_q  [WE];
  logic [AT_W-1:0]  wa_q  [WE];
  logic [PC_W-1:0]  wp_q  [WE];

  logic is_st, is_ld, is_br, same_val;
  assign is_st    = rt_valid && rt_kind == K_STORE;
  assign is_ld    = rt_valid && rt_kind == K_LOAD;
  assign is_br    = rt_valid && rt_kind == K_BRANCH;
  assign same_val = rt_wdata == rt_olddata;

  logic [WT_IDX_W-1:0] w_slot;
  logic [AT_W-1:0]     w_atag;
  logic                w_hit;
  logic [PC_W-1:0]     w_pc;
  assign w_slot = rt_addr[WT_IDX_W-1:0];
  assign w_atag = rt_addr[ADDR_W-1:WT_IDX_W];
  assign w_hit  = wv_q[w_slot] && wa_q[w_slot] == w_atag;
  assign w_pc   = wp_q[w_slot];

  logic                  a_en, a_inc, b_en, b_inc, b_live;
  logic [CONF_IDX_W-1:0] a_idx, b_idx;
  logic [TAG_W-1:0]      a_tag, b_tag;
  assign a_en   = is_br || (is_st && same_val);
  assign a_inc  = is_st || !rt_mispred;
  assign a_idx  = rt_pc[CONF_IDX_W-1:0];
  assign a_tag  = rt_pc[PC_W-1:CONF_IDX_W];
  assign b_en   = w_hit && (is_st || is_ld);
  assign b_inc  = is_st;
  assign b_idx  = w_pc[CONF_IDX_W-1:0];
  assign b_tag  = w_pc[PC_W-1:CONF_IDX_W];
  assign b_live = b_en && !(a_en && a_idx == b_idx);

  logic [CE-1:0] sel_v, hit_v, inc_v;
  logic [TAG_W-1:0] ntag_v [CE];

  for (genvar i = 0; i < CE; i++) begin : g_ent
    logic sa, sb;
    assign sa        = a_en && a_idx == CONF_IDX_W'(i);
    assign sb        = b_live && b_idx == CONF_IDX_W'(i);
    assign sel_v[i]  = sa || sb;
    assign ntag_v[i] = sa ? a_tag : b_tag;
    assign inc_v[i]  = sa ? a_inc : b_inc;
    assign hit_v[i]  = tag_q[i] == ntag_v[i];

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt_q[i] == '0);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !rt_valid) |=> ($stable(cnt_q[i]) && $stable(tag_q[i])));
    a_r2_mispredict_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && is_br && rt_mispred && a_idx == CONF_IDX_W'(i) && tag_q[i] == a_tag)
      |=> cnt_q[i] == '0);
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (cnt_q[i] <= ONE || cnt_q[i] == $past(cnt_q[i])
                  || {1'b0, cnt_q[i]} == {1'b0, $past(cnt_q[i])} + 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CE; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (flush) begin
      for (int i = 0; i < CE; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < CE; i++) begin
        if (sel_v[i]) begin
          if (hit_v[i]) begin
            if (!inc_v[i])             cnt_q[i] <= '0;
            else if (cnt_q[i] != CMAX) cnt_q[i] <= cnt_q[i] + ONE;
          end else if (inc_v[i]) begin
            tag_q[i] <= ntag_v[i];
            cnt_q[i] <= ONE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < WE; j++) begin
        wv_q[j] <= 1'b0;
        wa_q[j] <= '0;
        wp_q[j] <= '0;
      end
    end else if (flush) begin
      for (int j = 0; j < WE; j++) wv_q[j] <= 1'b0;
    end else begin
      for (int j = 0; j < WE; j++) begin
        if (w_slot == WT_IDX_W'(j)) begin
          if (is_st && !same_val) begin
            wv_q[j] <= 1'b1;
            wa_q[j] <= w_atag;
            wp_q[j] <= rt_pc;
          end else if ((is_st || is_ld) && w_hit) begin
            wv_q[j] <= 1'b0;
          end
        end
      end
    end
  end

  for (genvar j = 0; j < WE; j++) begin : g_slot
    a_r5_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && is_ld && w_hit && w_slot == WT_IDX_W'(j)) |=> !wv_q[j]);
    a_r4_install: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && is_st && !same_val && w_slot == WT_IDX_W'(j))
      |=> (wv_q[j] && wp_q[j] == $past(rt_pc)));
  end

  logic [CONF_IDX_W-1:0] lk_idx;
  assign lk_idx  = lk_pc[CONF_IDX_W-1:0];
  assign lk_skip = tag_q[lk_idx] == lk_pc[PC_W-1:CONF_IDX_W] && cnt_q[lk_idx] == CMAX;
endmodule

// File: tb/test_skip_trainer.sv
module test_skip_trainer;
  localparam int PC_W = 16, ADDR_W = 16, DATA_W = 32;
  localparam int CE = 16, WE = 8;
  localparam logic [1:0] K_OTH = 2'b00, K_ST = 2'b01, K_LD = 2'b10, K_BR = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, rt_valid = 1'b0, rt_mispred = 1'b0;
  logic [1:0] rt_kind = '0;
  logic [PC_W-1:0] rt_pc = '0, lk_pc = '0;
  logic [ADDR_W-1:0] rt_addr = '0;
  logic [DATA_W-1:0] rt_wdata = '0, rt_olddata = '0;
  logic lk_skip;

  always #10 clk = ~clk;

  skip_trainer i_skip_trainer (.clk, .rst_n, .flush, .rt_valid, .rt_kind, .rt_pc,
    .rt_addr, .rt_wdata, .rt_olddata, .rt_mispred, .lk_pc, .lk_skip);

  int checks = 0, errors = 0;
  int m_tag [CE]; int m_cnt [CE];
  bit m_wv [WE]; int m_wa [WE]; int m_wp [WE];

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  function automatic void m_apply(int pc, bit inc);
    int idx = pc % CE, tg = pc / CE;
    if (m_tag[idx] == tg) m_cnt[idx] = inc ? (m_cnt[idx] == 7 ? 7 : m_cnt[idx] + 1) : 0;
    else if (inc) begin m_tag[idx] = tg; m_cnt[idx] = 1; end
  endfunction

  function automatic void m_step(bit fl, bit v, logic [1:0] k, int pc, int addr, bit sv, bit mis);
    int slot = addr % WE, at = addr / WE;
    bit hit, aen, ben;
    if (fl) begin
      for (int i = 0; i < CE; i++) m_cnt[i] = 0;
      for (int j = 0; j < WE; j++) m_wv[j] = 0;
      return;
    end
    if (!v || k == K_OTH) return;
    hit = m_wv[slot] && m_wa[slot] == at;
    aen = (k == K_BR) || (k == K_ST && sv);
    ben = hit && (k == K_ST || k == K_LD);
    if (aen) m_apply(pc, k == K_ST || !mis);
    if (ben && !(aen && (m_wp[slot] % CE) == (pc % CE))) m_apply(m_wp[slot], k == K_ST);
    if (k == K_ST && !sv) begin m_wv[slot] = 1; m_wa[slot] = at; m_wp[slot] = pc; end
    else if (ben) m_wv[slot] = 0;
  endfunction

  function automatic bit m_skip(int pc);
    return m_tag[pc % CE] == pc / CE && m_cnt[pc % CE] == 7;
  endfunction

  task automatic step(bit fl, bit v, logic [1:0] k, int pc, int addr, int wd, int od, bit mis);
    flush = fl; rt_valid = v; rt_kind = k; rt_pc = PC_W'(pc); rt_addr = ADDR_W'(addr);
    rt_wdata = DATA_W'(wd); rt_olddata = DATA_W'(od); rt_mispred = mis;
    @(posedge clk);
    m_step(fl, v, k, pc, addr, wd == od, mis);
    @(negedge clk);
    flush = 0; rt_valid = 0; rt_kind = K_OTH;
  endtask

  task automatic br(int pc, bit mis);            step(0, 1, K_BR, pc, 0, 0, 0, mis); endtask
  task automatic st(int pc, int addr, bit chg);  step(0, 1, K_ST, pc, addr, chg ? 5 : 3, 3, 0); endtask
  task automatic ld(int pc, int addr);           step(0, 1, K_LD, pc, addr, 0, 0, 0); endtask

  task automatic chk(int pc, bit exp, string req);
    lk_pc = PC_W'(pc);
    #1;
    checks++;
    if (lk_skip !== exp) begin
      errors++;
      $display("FAIL %s: pc=%h skip actual=%b expected=%b", req, pc, lk_skip, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < CE; i++) begin m_tag[i] = 0; m_cnt[i] = 0; end
    for (int j = 0; j < WE; j++) begin m_wv[j] = 0; m_wa[j] = 0; m_wp[j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk('h0, 0, "R1"); chk('h21, 0, "R1");

    // R2 and R6: threshold, saturation, mispredict clear
    repeat (6) br('h21, 0);
    chk('h21, 0, "R6 below threshold");
    br('h21, 0);  chk('h21, 1, "R2 trained branch");
    br('h21, 0);  chk('h21, 1, "R6 saturation");
    br('h21, 1);  chk('h21, 0, "R2 mispredict clear");

    // R3: non-modifying store
    repeat (6) st('h30, 'h40, 0);
    chk('h30, 0, "R3 six events");
    st('h30, 'h40, 0); chk('h30, 1, "R3 non-modifying store");

    // R4: alternating overwrites of one address
    for (int n = 0; n < 7; n++) begin st('h42, 'h10, 1); st('h55, 'h10, 1); end
    chk('h42, 1, "R4 unreferenced write credited");
    chk('h55, 0, "R4 one credit short");

    // R5: load resets pending writer and clears record
    ld('h99, 'h10);                    // clears 0x55 record
    st('h42, 'h10, 1);                 // no credit, installs 0x42
    chk('h42, 1, "R5 cleared record gives no change");
    ld('h99, 'h10);
    chk('h42, 0, "R5 read resets writer");
    st('h55, 'h10, 1);
    chk('h42, 0, "R5 record removed after read");

    // R7: replacement on tag conflict
    repeat (7) br('h13, 0);
    chk('h13, 1, "R7 setup");
    br('h23, 1);  chk('h13, 1, "R7 clear on other tag ignored");
    br('h23, 0);  chk('h13, 0, "R7 entry replaced");
    repeat (5) br('h23, 0);
    chk('h23, 0, "R7 count restarts at 1");
    br('h23, 0);  chk('h23, 1, "R7 new tag trained");

    // R10: invalid or other-kind retirements have no effect
    step(0, 0, K_BR, 'h23, 0, 0, 0, 1);
    step(0, 1, K_OTH, 'h23, 0, 0, 0, 1);
    chk('h23, 1, "R10 no effect");

    // R9: flush clears and beats a simultaneous retirement
    step(1, 1, K_BR, 'h23, 0, 0, 0, 0);
    chk('h23, 0, "R9 flush clears");
    repeat (6) br('h23, 0);
    chk('h23, 0, "R9 retirement during flush ignored");
    br('h23, 0);  chk('h23, 1, "R9 retrain after flush");

    // R8: own event and pending credit on same entry count once
    for (int n = 0; n < 4; n++) begin st('h18, 'h9, 1); st('h18, 'h9, 0); end
    chk('h18, 0, "R8 single increment per cycle");
    for (int n = 0; n < 3; n++) begin st('h18, 'h9, 1); st('h18, 'h9, 0); end
    chk('h18, 1, "R8 trained after seven");

    // R11: slot conflict drops the older pending write
    repeat (6) st('h3A, 'h30, 0);
    st('h3A, 'h1, 1);
    st('h4B, 'h9, 1);
    st('h5C, 'h1, 1);
    chk('h3A, 0, "R11 replaced record gives no credit");

    // Random phase against the shadow model (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
    for (int n = 0; n < 4000; n++) begin
      int pool [6] = '{'h21, 'h30, 'h42, 'h55, 'h13, 'h23};
      int pc, lpc;
      pc  = ($urandom % 10 < 7) ? pool[$urandom % 6] : int'($urandom % 64);
      lpc = ($urandom % 10 < 7) ? pool[$urandom % 6] : int'($urandom % 64);
      step(($urandom % 300) == 0, ($urandom % 10) != 0, 2'($urandom), pc,
           int'($urandom % 32), int'($urandom % 3), int'($urandom % 3), ($urandom % 6) == 0);
      chk(lpc, m_skip(lpc), "R6 random vs model");
    end
    report();
  end
endmodule